// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block holds three independent 16-bit down counters behind a byte-wide register interface with four addresses. Addresses 0, 1 and 2 reach the count register of channel 0, 1 and 2. Address 3 takes a command byte. That byte either reprograms one channel or freezes a snapshot of that channel's count so that software can read it while the counter keeps running. Each channel counts down once per clock while its enable input is high. It drives one output whose waveform depends on the programmed counting mode.

Two counting behaviours are built. The first is a terminal-count output that stays high once reached. The second is a rate generator that produces a one-clock low pulse every N clocks. Any other mode code is stored but runs as the terminal-count behaviour. A channel counts in plain binary or in four-digit packed decimal. Each channel is a small state machine with four states. CH_IDLE is entered on reset and on every command that reprograms the channel, and the counter holds there. CH_ARMED is entered when the last byte of a count is written. CH_COUNT is entered from CH_ARMED on the next clock, when the counter loads the new count. CH_TERM is entered from CH_COUNT in terminal-count mode when the counter steps from 1 to 0. In CH_COUNT and CH_TERM the counter keeps decrementing while enabled. Writing a complete count from any state goes to CH_ARMED. Reprogramming the channel from any state goes to CH_IDLE.

Top module: `tri_interval_timer`

## Requirements
- R1: After reset every output is high and every counter holds 0. Each channel powers up in low-then-high byte access, terminal-count mode and binary, so reading address 0 returns 0x00.
- R2: A write to address 3 is decoded as follows. Bits 7:6 choose the channel: 00 is channel 0, 01 is channel 1, 10 is channel 2, and 11 is ignored. Bits 5:4 give the access: 00 is a latch command, 01 is low byte only, 10 is high byte only, 11 is low then high. Bits 3:1 give the mode code and bit 0 selects decimal counting. A command reaches only the channel it selects.
- R3: In low-only access a data write loads {0x00, byte}. In high-only access it loads {byte, 0x00}. In low-then-high access the low byte is written first and the count is complete only when the high byte is written. The counter takes the new count on the clock after the final byte.
- R4: While a channel's enable input is low, its counter holds its value.
- R5: In mode code 0 the output goes low on the command write and on each completed count write. It goes high on the clock where the counter steps from 1 to 0 and stays high while the counter wraps and continues.
- R6: In mode code 2 the output is low exactly while the count equals 1. On an enabled clock at count 1 the counter reloads the initial count, so an initial count N gives an output period of N clocks.
- R7: Every mode code other than 2 is stored but behaves as mode code 0. The output does not pulse and the count does not reload.
- R8: A latch command copies the live count into a snapshot, and reads return the snapshot while counting continues. The snapshot is released after one read in single-byte access, or after both bytes are read in low-then-high access. A latch command that arrives before the release is ignored.
- R9: In low-then-high access, reads alternate low byte then high byte, and writes do the same. A command write resets both byte pointers to the low byte.
- R10: An initial count of 0 counts as 65536 in binary and as 10000 in decimal. A decrement from 0 gives 0xFFFF in binary and 0x9999 in decimal.
- R11: In decimal mode each 4-bit digit steps from 0 to 9 with a borrow from the digit above, so 0x0100 decrements to 0x0099.
- R12: Reading address 3 returns 0x00. A count completed while a channel is already counting restarts that channel with the new count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; counters step on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one clock |
| rd_en | input | 1 | Read strobe for one clock; advances the read byte pointer and releases a snapshot |
| addr | input | 2 | Register address: 0 to 2 for the channel counts, 3 for commands |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte, valid in the same cycle as addr |
| cnt_en | input | 3 | Per-channel count enable |
| tmr_out | output | 3 | Per-channel timer output |

## Verification
The terminal-count mode is tried with short counts, so that the rising edge lands on a known clock and the counter can then be seen wrapping. The rate generator is driven with N=4 and its low pulses are counted over three periods. A mode code of 3 separates the stored-but-defaulted modes from the rate generator. Counts are loaded in low-only, high-only and two-byte access. A low byte is abandoned before a command write, which separates correct pointer reset from a stale pointer. Decimal zero and decimal 0x0100 expose the digit borrow chain, and a binary zero exposes the 16-bit wrap. A double latch with reads delayed by several clocks separates a frozen snapshot from a live or retaken one. A behavioural model also compares every output and every read byte on every clock.

// File: rtl/pit_pkg.sv
package pit_pkg;
    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;
    localparam int DIG_N  = CNT_W / 4;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LO    = 2'b01,
        ACC_HI    = 2'b10,
        ACC_BOTH  = 2'b11
    } acc_e;

    typedef enum logic [1:0] {
        CH_IDLE,
        CH_ARMED,
        CH_COUNT,
        CH_TERM
    } ch_state_e;

    localparam logic [2:0] MODE_RATE = 3'd2;

    typedef struct packed {
        logic [1:0] sel;
        acc_e       acc;
        logic [2:0] mode;
        logic       bcd;
    } ctl_word_t;
endpackage

// File: rtl/pit_decrement.sv
module pit_decrement
    import pit_pkg::*;
(
    input  logic [CNT_W-1:0] val,
    input  logic             bcd,
    output logic [CNT_W-1:0] nxt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [DIG_N-1:0] borrow;
    logic [CNT_W-1:0] bcd_nxt;

    assign borrow[0] = 1'b1;

    // Ripple borrow through the decimal digits
    generate
        for (genvar d = 0; d < DIG_N; d++) begin : g_dig
            logic [3:0] dig;
            assign dig = val[4*d +: 4];
            assign bcd_nxt[4*d +: 4] = borrow[d] ? ((dig == 4'd0) ? 4'd9 : dig - 4'd1) : dig;
            if (d < DIG_N - 1) begin : g_chain
                assign borrow[d+1] = borrow[d] && (dig == 4'd0);
            end
        end
    endgenerate

    assign nxt = bcd ? bcd_nxt : (val - ONE);
endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  acc_e              ctl_acc,
    input  logic [2:0]        ctl_mode,
    input  logic              ctl_bcd,
    input  logic              latch_cmd,
    input  logic              data_wr,
    input  logic              data_rd,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              cnt_en,
    output logic [BYTE_W-1:0] rdata,
    output logic              out
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam int PAD_W = CNT_W - BYTE_W;

    ch_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_dec, init_q, snap_q, load_val, rd_src;
    logic [BYTE_W-1:0] pend_lo_q;
    logic [2:0]        mode_q;
    acc_e              acc_q;
    logic              bcd_q, wtog_q, rtog_q, latched_q, out_q, out_d;
    logic              is_rate, rate_d, load_done, rd_done;

    pit_decrement u_dec (.val(cnt_q), .bcd(bcd_q), .nxt(cnt_dec));

    assign is_rate   = (mode_q == MODE_RATE);
    assign rate_d    = ctl_wr ? (ctl_mode == MODE_RATE) : is_rate;
    assign load_done = data_wr && ((acc_q != ACC_BOTH) || wtog_q);
    assign rd_done   = data_rd && ((acc_q != ACC_BOTH) || rtog_q);

    always_comb begin
        case (acc_q)
            ACC_LO:  load_val = {{PAD_W{1'b0}}, wdata};
            ACC_HI:  load_val = {wdata, {PAD_W{1'b0}}};
            default: load_val = {wdata, pend_lo_q};
        endcase
    end

    // Next state and next count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (ctl_wr) begin
            state_d = CH_IDLE;
        end else if (load_done) begin
            state_d = CH_ARMED;
        end else begin
            unique case (state_q)
                CH_IDLE: ;
                CH_ARMED: begin
                    cnt_d   = init_q;
                    state_d = CH_COUNT;
                end
                CH_COUNT: begin
                    if (cnt_en) begin
                        if (is_rate && cnt_q == CNT_ONE) begin
                            cnt_d = init_q;
                        end else begin
                            cnt_d = cnt_dec;
                            if (!is_rate && cnt_q == CNT_ONE) state_d = CH_TERM;
                        end
                    end
                end
                CH_TERM: begin
                    if (cnt_en) cnt_d = cnt_dec;
                end
            endcase
        end
    end

    // Next output level
    always_comb begin
        out_d = out_q;
        if (rate_d)                  out_d = !(state_d == CH_COUNT && cnt_d == CNT_ONE);
        else if (ctl_wr || load_done) out_d = 1'b0;
        else if (state_d == CH_TERM)  out_d = 1'b1;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= 1'b1;
        else        out_q <= out_d;
    end

    // Programming, byte pointers and snapshot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= 3'd0;
            acc_q     <= ACC_BOTH;
            bcd_q     <= 1'b0;
            wtog_q    <= 1'b0;
            rtog_q    <= 1'b0;
            pend_lo_q <= '0;
            init_q    <= '0;
            latched_q <= 1'b0;
            snap_q    <= '0;
        end else if (ctl_wr) begin
            mode_q    <= ctl_mode;
            acc_q     <= ctl_acc;
            bcd_q     <= ctl_bcd;
            wtog_q    <= 1'b0;
            rtog_q    <= 1'b0;
            latched_q <= 1'b0;
        end else begin
            if (data_wr) begin
                if (acc_q == ACC_BOTH) wtog_q <= !wtog_q;
                if (acc_q == ACC_BOTH && !wtog_q) pend_lo_q <= wdata;
                if (load_done) init_q <= load_val;
            end
            if (data_rd && acc_q == ACC_BOTH) rtog_q <= !rtog_q;
            if (rd_done) latched_q <= 1'b0;
            if (latch_cmd && !latched_q) begin
                snap_q    <= cnt_q;
                latched_q <= 1'b1;
            end
        end
    end

    assign rd_src = latched_q ? snap_q : cnt_q;
    assign rdata  = ((acc_q == ACC_HI) || (acc_q == ACC_BOTH && rtog_q)) ?
                    rd_src[CNT_W-1 -: BYTE_W] : rd_src[BYTE_W-1:0];
    assign out    = out_q;

    AST_HOLD_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_COUNT && !cnt_en && !ctl_wr && !load_done) |=> (cnt_q == $past(cnt_q))); // R4
    AST_TERM_OUT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_TERM) |-> out_q); // R5
    AST_ARMED_OUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_ARMED && !is_rate) |-> !out_q); // R5
    AST_RATE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_COUNT && is_rate && cnt_en && cnt_q == CNT_ONE && !ctl_wr && !load_done)
        |=> (cnt_q == $past(init_q))); // R6
    AST_RATE_OUT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_COUNT && is_rate) |-> (out_q == (cnt_q != CNT_ONE))); // R6
    AST_SNAPSHOT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (latched_q && $past(latched_q)) |-> $stable(snap_q)); // R8
endmodule

// File: rtl/tri_interval_timer.sv
module tri_interval_timer
    import pit_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [1:0]          addr,
    input  logic [BYTE_W-1:0]   wdata,
    output logic [BYTE_W-1:0]   rdata,
    input  logic [NUM_CH-1:0]   cnt_en,
    output logic [NUM_CH-1:0]   tmr_out
);
    localparam int AW = 2;
    localparam logic [AW-1:0] CTL_ADDR = AW'(NUM_CH);

    ctl_word_t         cw;
    logic              ctl_hit;
    logic [BYTE_W-1:0] ch_rdata [NUM_CH];

    assign cw      = ctl_word_t'(wdata);
    assign ctl_hit = wr_en && (addr == CTL_ADDR);

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
            logic sel_hit;
            assign sel_hit = ctl_hit && (cw.sel == 2'(ch));

            pit_channel u_ch (
                .clk       (clk),
                .rst_n     (rst_n),
                .ctl_wr    (sel_hit && (cw.acc != ACC_LATCH)),
                .ctl_acc   (cw.acc),
                .ctl_mode  (cw.mode),
                .ctl_bcd   (cw.bcd),
                .latch_cmd (sel_hit && (cw.acc == ACC_LATCH)),
                .data_wr   (wr_en && (addr == AW'(ch))),
                .data_rd   (rd_en && (addr == AW'(ch))),
                .wdata     (wdata),
                .cnt_en    (cnt_en[ch]),
                .rdata     (ch_rdata[ch]),
                .out       (tmr_out[ch])
            );
        end
    endgenerate

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == AW'(i)) rdata = ch_rdata[i];
        end
    end
endmodule

// File: tb/sim_tri_interval_timer.sv
`timescale 1ns/1ps
module sim_tri_interval_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic [2:0] cnt_en = 3'b000;
    logic [2:0] tmr_out;

    int checks = 0, fails = 0, cycles = 0;
    bit finished = 0;
    string phase_req = "R1";

    // Behavioural model state per channel
    int m_cnt[3], m_init[3], m_st[3], m_out[3], m_mode[3], m_acc[3], m_bcd[3];
    int m_wt[3], m_rt[3], m_pl[3], m_lat[3], m_snap[3];

    tri_interval_timer u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
                           .wdata(wdata), .rdata(rdata), .cnt_en(cnt_en), .tmr_out(tmr_out));

    always #5 clk = ~clk;

    function automatic int mdec(int v, int b);
        int n;
        if (b == 0) return (v + 65535) % 65536;
        n = ((v >> 12) & 15) * 1000 + ((v >> 8) & 15) * 100 + ((v >> 4) & 15) * 10 + (v & 15);
        n = (n == 0) ? 9999 : n - 1;
        return ((n / 1000) << 12) | (((n / 100) % 10) << 8) | (((n / 10) % 10) << 4) | (n % 10);
    endfunction

    function automatic int exp_rd();
        int c, src;
        if (addr == 2'd3) return 0;
        c = int'(addr);
        src = m_lat[c] ? m_snap[c] : m_cnt[c];
        if (m_acc[c] == 2 || (m_acc[c] == 3 && m_rt[c] != 0)) return (src >> 8) & 255;
        return src & 255;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            for (int c = 0; c < 3; c++) begin
                m_cnt[c] = 0; m_init[c] = 0; m_st[c] = 0; m_out[c] = 1; m_mode[c] = 0;
                m_acc[c] = 3; m_bcd[c] = 0; m_wt[c] = 0; m_rt[c] = 0; m_pl[c] = 0;
                m_lat[c] = 0; m_snap[c] = 0;
            end
        end else begin
            for (int c = 0; c < 3; c++) begin
                int ocnt, olat;
                bit ctl, lat, dw, dr, done, rdone, rate;
                ocnt  = m_cnt[c];
                olat  = m_lat[c];
                ctl   = wr_en && addr == 2'd3 && int'(wdata[7:6]) == c && wdata[5:4] != 2'b00;
                lat   = wr_en && addr == 2'd3 && int'(wdata[7:6]) == c && wdata[5:4] == 2'b00;
                dw    = wr_en && int'(addr) == c;
                dr    = rd_en && int'(addr) == c;
                done  = dw && (m_acc[c] != 3 || m_wt[c] != 0);
                rdone = dr && (m_acc[c] != 3 || m_rt[c] != 0);
                if (ctl) m_st[c] = 0;
                else if (done) m_st[c] = 1;
                else if (m_st[c] == 1) begin m_cnt[c] = m_init[c]; m_st[c] = 2; end
                else if (m_st[c] == 2 && cnt_en[c]) begin
                    if (m_mode[c] == 2 && ocnt == 1) m_cnt[c] = m_init[c];
                    else begin
                        if (m_mode[c] != 2 && ocnt == 1) m_st[c] = 3;
                        m_cnt[c] = mdec(ocnt, m_bcd[c]);
                    end
                end else if (m_st[c] == 3 && cnt_en[c]) m_cnt[c] = mdec(ocnt, m_bcd[c]);
                rate = ctl ? (wdata[3:1] == 3'd2) : (m_mode[c] == 2);
                if (rate) m_out[c] = !(m_st[c] == 2 && m_cnt[c] == 1);
                else if (ctl || done) m_out[c] = 0;
                else if (m_st[c] == 3) m_out[c] = 1;
                if (ctl) begin
                    m_mode[c] = int'(wdata[3:1]); m_acc[c] = int'(wdata[5:4]); m_bcd[c] = int'(wdata[0]);
                    m_wt[c] = 0; m_rt[c] = 0; m_lat[c] = 0;
                end else begin
                    if (dw) begin
                        if (m_acc[c] == 1) m_init[c] = int'(wdata);
                        else if (m_acc[c] == 2) m_init[c] = int'(wdata) * 256;
                        else if (m_wt[c] == 0) begin m_pl[c] = int'(wdata); m_wt[c] = 1; end
                        else begin m_init[c] = int'(wdata) * 256 + m_pl[c]; m_wt[c] = 0; end
                    end
                    if (dr && m_acc[c] == 3) m_rt[c] = (m_rt[c] == 0) ? 1 : 0;
                    if (rdone) m_lat[c] = 0;
                    if (lat && olat == 0) begin m_snap[c] = ocnt; m_lat[c] = 1; end
                end
            end
        end
        if (cycles > 100000 && !finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL all requirements: watchdog actual %0d cycles expected below 100000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Compare against the model on every clock
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            for (int c = 0; c < 3; c++) begin
                checks++;
                if (int'(tmr_out[c]) != m_out[c]) begin
                    fails++;
                    $display("FAIL %s: tmr_out[%0d] actual %0d expected %0d", phase_req, c, tmr_out[c], m_out[c]);
                end
            end
            checks++;
            if (int'(rdata) != exp_rd()) begin
                fails++;
                $display("FAIL %s: rdata actual %0h expected %0h", phase_req, rdata, exp_rd());
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n = 1);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr(input int a, input int d);
        addr = 2'(a); wdata = 8'(d); wr_en = 1'b1;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        addr = 2'(a); rd_en = 1'b1;
        #1;
        v = int'(rdata);
        cyc();
        rd_en = 1'b0;
    endtask

    initial begin
        int v, lows;
        logic [2:0] saved;
        cyc(3);
        rst_n = 1'b1;
        cyc();
        phase_req = "R1";
        check("R1 outputs after reset", int'(tmr_out), 7);
        rd(0, v);
        check("R1 counter reads zero", v, 0);

        // Terminal-count mode, two-byte load
        phase_req = "R5";
        cnt_en = 3'b111;
        wr(3, 8'h30);
        check("R2 select ch0 only", int'(tmr_out), 6);
        check("R5 low after command", int'(tmr_out[0]), 0);
        wr(0, 5); wr(0, 0);
        cyc(5);
        check("R5 still low before terminal", int'(tmr_out[0]), 0);
        cyc();
        check("R5 high at terminal", int'(tmr_out[0]), 1);
        cyc(3);
        check("R5 stays high", int'(tmr_out[0]), 1);
        rd(0, v);
        check("R10 binary wrap low byte", v, 8'hFD);
        rd(0, v);
        check("R10 binary wrap high byte", v, 8'hFF);

        // Enable hold, single-byte access
        phase_req = "R4";
        cnt_en[1] = 1'b0;
        wr(3, 8'h50);
        wr(1, 8'h10);
        cyc(3);
        rd(1, v);
        check("R4 hold while disabled / R3 low-only load", v, 8'h10);
        cnt_en[1] = 1'b1;
        cyc(4);
        rd(1, v);
        check("R4 counts when enabled", v, 8'h0C);
        phase_req = "R3";
        wr(3, 8'h60);
        wr(1, 8'h02);
        cyc(2);
        rd(1, v);
        check("R3 high-only load", v, 8'h01);

        // Rate generator
        phase_req = "R6";
        wr(3, 8'hB4);
        wr(2, 4); wr(2, 0);
        lows = 0;
        for (int i = 0; i < 12; i++) begin
            cyc();
            if (tmr_out[2] == 1'b0) lows++;
        end
        check("R6 one low clock per 4-clock period", lows, 3);

        // Latch snapshot
        phase_req = "R8";
        wr(3, 8'h30);
        wr(0, 8'h34); wr(0, 8'h12);
        cyc(2);
        wr(3, 8'h00);
        cyc(2);
        wr(3, 8'h00);
        cyc();
        rd(0, v);
        check("R8 snapshot low byte", v, 8'h33);
        rd(0, v);
        check("R8 snapshot high byte, second latch ignored", v, 8'h12);

        // Byte pointer reset by command
        phase_req = "R9";
        wr(0, 8'h08);
        wr(3, 8'h30);
        wr(0, 2); wr(0, 0);
        cyc(2);
        check("R9 low before terminal", int'(tmr_out[0]), 0);
        cyc();
        check("R9 pointer reset gives count 2", int'(tmr_out[0]), 1);

        // Decimal counting
        phase_req = "R10";
        wr(3, 8'h71);
        wr(1, 0); wr(1, 0);
        cyc(2);
        wr(3, 8'h40);
        rd(1, v);
        check("R10 decimal zero wraps low", v, 8'h99);
        rd(1, v);
        check("R10 decimal zero wraps high", v, 8'h99);
        phase_req = "R11";
        wr(3, 8'h71);
        wr(1, 8'h00); wr(1, 8'h01);
        cyc(2);
        wr(3, 8'h40);
        rd(1, v);
        check("R11 decimal borrow low", v, 8'h99);
        rd(1, v);
        check("R11 decimal borrow high", v, 8'h00);
        phase_req = "R10";
        wr(3, 8'hB0);
        wr(2, 0); wr(2, 0);
        cyc(2);
        wr(3, 8'h80);
        rd(2, v);
        check("R10 binary zero low", v, 8'hFF);
        rd(2, v);
        check("R10 binary zero high", v, 8'hFF);

        // Other mode code behaves as terminal count
        phase_req = "R7";
        wr(3, 8'hB6);
        check("R7 low after command", int'(tmr_out[2]), 0);
        wr(2, 3); wr(2, 0);
        cyc(3);
        check("R7 low before terminal", int'(tmr_out[2]), 0);
        cyc();
        check("R7 high at terminal", int'(tmr_out[2]), 1);
        cyc(4);
        check("R7 no reload pulse", int'(tmr_out[2]), 1);

        // Select 11 ignored, control address reads zero
        phase_req = "R2";
        saved = tmr_out;
        wr(3, 8'hF0);
        cyc();
        check("R2 select 11 ignored", int'(tmr_out), int'(saved));
        phase_req = "R12";
        rd(3, v);
        check("R12 control address reads zero", v, 0);

        // Restart with a new count
        wr(3, 8'hB0);
        wr(2, 20); wr(2, 0);
        cyc(5);
        wr(2, 3); wr(2, 0);
        cyc(3);
        check("R12 low before restarted terminal", int'(tmr_out[2]), 0);
        cyc();
        check("R12 restarted count reaches terminal", int'(tmr_out[2]), 1);

        cyc(5);
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule